// File: doc/BRIEF.md
# Single-Beat Lightweight Uncached Memory Device

This block is the device end of a TileLink Uncached Lightweight link with a 32-bit data path. It holds a small word-addressed register array and serves one request at a time. The host presents a read, a full-word write or a byte-masked write on the request channel. One cycle after the request is accepted, the device answers on the response channel. A write gets a plain acknowledge and a read gets an acknowledge that carries data.

A masked write changes only the byte lanes whose mask bits are set, and the set lanes need not be adjacent. A read always returns the whole addressed word. The host then keeps the lanes it asked for. Each response echoes the size and source tag of the request that caused it. An address past the end of the array, or an opcode the device does not serve, produces an error response and leaves the array unchanged.

Top module: `tlul_mem_dev`

## Requirements
- R1: After reset, d_valid_o is 0 and a_ready_o is 1, and every word of the array reads back as 0.
- R2: A request with a_opcode_i = 4 (Get) to an address in range gets a response with d_opcode_o = 1 and d_error_o = 0. d_data_o carries the whole word at index a_address_i[N+1:2], where N = log2(DEPTH), whatever a_mask_i is.
- R3: A request with a_opcode_i = 1 (PutPartialData) gets a response with d_opcode_o = 0. It writes byte lane k (bits 8k+7:8k) from a_data_i only where a_mask_i[k] = 1, and gaps in the mask are allowed. Its d_data_o is 0.
- R4: A request with a_opcode_i = 0 (PutFullData) and a_mask_i = 4'b1111 replaces all four byte lanes of the addressed word and gets a response with d_opcode_o = 0.
- R5: Every response carries the request's a_size_i in d_size_o and its a_source_i in d_source_o.
- R6: d_valid_o rises in the cycle after a request is accepted. While d_ready_i is 0, the response and all of its fields stay unchanged.
- R7: a_ready_o is 0 while d_valid_o = 1 and d_ready_i = 0. A request offered in that state is not accepted and writes nothing.
- R8: A request whose a_address_i[31:2] is DEPTH or more gets d_error_o = 1 and d_data_o = 0, and writes nothing. Its d_opcode_o is still 1 for a Get and 0 for a write.
- R9: A request with any other opcode value gets d_opcode_o = 0 and d_error_o = 1, and writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_valid_i | input | 1 | Request valid |
| a_ready_o | output | 1 | Device can accept a request |
| a_opcode_i | input | 3 | Request opcode: 0 full write, 1 masked write, 4 read |
| a_size_i | input | 2 | log2 of the access size in bytes |
| a_source_i | input | SRC_W | Requester tag |
| a_address_i | input | AW | Byte address |
| a_mask_i | input | DW/8 | Byte-lane mask |
| a_data_i | input | DW | Write data |
| d_valid_o | output | 1 | Response valid |
| d_ready_i | input | 1 | Host accepts the response |
| d_opcode_o | output | 3 | 0 acknowledge, 1 acknowledge with data |
| d_size_o | output | 2 | Echo of a_size_i |
| d_source_o | output | SRC_W | Echo of a_source_i |
| d_data_o | output | DW | Read data |
| d_error_o | output | 1 | Address out of range or opcode not served |

## Verification
Every word is first written with a full-word write of a value derived from its index, and every word is then read back. This shows that each index decodes to its own word and that the writes do not alias. Next, all sixteen mask values are swept as masked writes over a known word, with a read after each. Gapped masks, single lanes and the empty mask each show whether only the enabled lanes change. Sizes 0 to 2 and several source tags test the echo. Out-of-range addresses, an unserved opcode and a stalled response test the error path and the back-pressure rule, and each of these is followed by a read that shows nothing was written.

// File: rtl/tlul_mem_pkg.sv
package tlul_mem_pkg;
  localparam logic [2:0] OP_PUT_FULL = 3'd0;
  localparam logic [2:0] OP_PUT_PART = 3'd1;
  localparam logic [2:0] OP_GET      = 3'd4;
  localparam logic [2:0] RSP_ACK      = 3'd0;
  localparam logic [2:0] RSP_ACK_DATA = 3'd1;
endpackage

// File: rtl/tlul_req_decode.sv
module tlul_req_decode import tlul_mem_pkg::*; #(
  parameter int AW    = 32,
  parameter int DEPTH = 16,
  parameter int LANES = 4,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic [2:0]       opcode_i,
  input  logic [AW-1:0]    address_i,
  input  logic [LANES-1:0] mask_i,
  input  logic             accept_i,
  output logic [IDX_W-1:0] idx_o,
  output logic [LANES-1:0] lane_we_o,
  output logic [2:0]       rsp_opcode_o,
  output logic             err_o
);
  logic is_get, is_put, in_range;
  logic unused_low;
  assign unused_low = ^address_i[1:0];

  assign is_get   = (opcode_i == OP_GET);
  assign is_put   = (opcode_i == OP_PUT_FULL) || (opcode_i == OP_PUT_PART);
  assign in_range = address_i[AW-1:2] < (AW-2)'(DEPTH);
  assign idx_o    = address_i[IDX_W+1:2];
  assign err_o    = !(is_get || is_put) || !in_range;
  assign rsp_opcode_o = is_get ? RSP_ACK_DATA : RSP_ACK;
  // write lanes only on an accepted, legal, in-range write
  assign lane_we_o = (accept_i && is_put && !err_o) ? mask_i : '0;
endmodule

// File: rtl/tlul_byte_mem.sv
module tlul_byte_mem #(
  parameter int DEPTH = 16,
  parameter int LANES = 4,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [IDX_W-1:0]     idx_i,
  input  logic [LANES-1:0]     lane_we_i,
  input  logic [8*LANES-1:0]   wdata_i,
  output logic [8*LANES-1:0]   rdata_o
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [7:0] mem_q [DEPTH];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int w = 0; w < DEPTH; w++) mem_q[w] <= '0;
      end else if (lane_we_i[l]) begin
        mem_q[idx_i] <= wdata_i[8*l +: 8];
      end
    end
    assign rdata_o[8*l +: 8] = mem_q[idx_i];
  end
endmodule

// File: rtl/tlul_rsp_reg.sv
module tlul_rsp_reg import tlul_mem_pkg::*; #(
  parameter int DW    = 32,
  parameter int SRC_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             accept_i,
  input  logic [2:0]       opcode_i,
  input  logic [1:0]       size_i,
  input  logic [SRC_W-1:0] source_i,
  input  logic [DW-1:0]    rdata_i,
  input  logic             err_i,
  input  logic             d_ready_i,
  output logic             d_valid_o,
  output logic [2:0]       d_opcode_o,
  output logic [1:0]       d_size_o,
  output logic [SRC_W-1:0] d_source_o,
  output logic [DW-1:0]    d_data_o,
  output logic             d_error_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      d_valid_o  <= 1'b0;
      d_opcode_o <= RSP_ACK;
      d_size_o   <= '0;
      d_source_o <= '0;
      d_data_o   <= '0;
      d_error_o  <= 1'b0;
    end else if (accept_i) begin
      d_valid_o  <= 1'b1;
      d_opcode_o <= opcode_i;
      d_size_o   <= size_i;
      d_source_o <= source_i;
      d_data_o   <= (opcode_i == RSP_ACK_DATA && !err_i) ? rdata_i : '0;
      d_error_o  <= err_i;
    end else if (d_ready_i) begin
      d_valid_o  <= 1'b0;
    end
  end

  assert_rsp_after_accept_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_i |=> d_valid_o);
  assert_rsp_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (d_valid_o && !d_ready_i) |=> (d_valid_o && $stable(d_data_o) && $stable(d_source_o)
                                   && $stable(d_size_o) && $stable(d_opcode_o)));
  assert_no_accept_stalled_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (d_valid_o && !d_ready_i) |-> !accept_i);
  assert_echo_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_i |=> (d_size_o == $past(size_i) && d_source_o == $past(source_i)));
  assert_opcode_legal_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    d_valid_o |-> (d_opcode_o == RSP_ACK || d_opcode_o == RSP_ACK_DATA));
endmodule

// File: rtl/tlul_mem_dev.sv
module tlul_mem_dev import tlul_mem_pkg::*; #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int SRC_W = 8,
  parameter int DEPTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             a_valid_i,
  output logic             a_ready_o,
  input  logic [2:0]       a_opcode_i,
  input  logic [1:0]       a_size_i,
  input  logic [SRC_W-1:0] a_source_i,
  input  logic [AW-1:0]    a_address_i,
  input  logic [DW/8-1:0]  a_mask_i,
  input  logic [DW-1:0]    a_data_i,
  output logic             d_valid_o,
  input  logic             d_ready_i,
  output logic [2:0]       d_opcode_o,
  output logic [1:0]       d_size_o,
  output logic [SRC_W-1:0] d_source_o,
  output logic [DW-1:0]    d_data_o,
  output logic             d_error_o
);
  localparam int LANES = DW / 8;
  localparam int IDX_W = $clog2(DEPTH);

  logic             accept;
  logic [IDX_W-1:0] idx;
  logic [LANES-1:0] lane_we;
  logic [2:0]       rsp_opcode;
  logic             err;
  logic [DW-1:0]    rdata;

  assign a_ready_o = !d_valid_o || d_ready_i;
  assign accept    = a_valid_i && a_ready_o;

  tlul_req_decode #(.AW(AW), .DEPTH(DEPTH), .LANES(LANES), .IDX_W(IDX_W)) u_dec (
    .opcode_i(a_opcode_i), .address_i(a_address_i), .mask_i(a_mask_i), .accept_i(accept),
    .idx_o(idx), .lane_we_o(lane_we), .rsp_opcode_o(rsp_opcode), .err_o(err)
  );

  tlul_byte_mem #(.DEPTH(DEPTH), .LANES(LANES), .IDX_W(IDX_W)) u_mem (
    .clk_i(clk_i), .rst_ni(rst_ni), .idx_i(idx), .lane_we_i(lane_we),
    .wdata_i(a_data_i), .rdata_o(rdata)
  );

  tlul_rsp_reg #(.DW(DW), .SRC_W(SRC_W)) u_rsp (
    .clk_i(clk_i), .rst_ni(rst_ni), .accept_i(accept), .opcode_i(rsp_opcode),
    .size_i(a_size_i), .source_i(a_source_i), .rdata_i(rdata), .err_i(err),
    .d_ready_i(d_ready_i), .d_valid_o(d_valid_o), .d_opcode_o(d_opcode_o),
    .d_size_o(d_size_o), .d_source_o(d_source_o), .d_data_o(d_data_o),
    .d_error_o(d_error_o)
  );

  assert_no_write_oob_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|lane_we) |-> (a_valid_i && a_address_i[AW-1:2] < (AW-2)'(DEPTH)));
  assert_no_write_badop_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|lane_we) |-> (a_opcode_i == OP_PUT_FULL || a_opcode_i == OP_PUT_PART));
  assert_get_rsp_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && a_opcode_i == OP_GET) |=> (d_opcode_o == RSP_ACK_DATA));
endmodule

// File: tb/tlul_mem_dev_tb.sv
module tlul_mem_dev_tb;
  localparam int DEPTH = 16;
  logic clk = 0, rst_ni = 0;
  logic a_valid = 0, d_ready = 1;
  logic [2:0] a_opcode = 0;
  logic [1:0] a_size = 0;
  logic [7:0] a_source = 0;
  logic [31:0] a_address = 0, a_data = 0;
  logic [3:0] a_mask = 0;
  logic a_ready, d_valid, d_error;
  logic [2:0] d_opcode;
  logic [1:0] d_size;
  logic [7:0] d_source;
  logic [31:0] d_data;
  int n_chk = 0, n_fail = 0;
  logic [31:0] model [DEPTH];

  always #2.5 clk = ~clk;

  tlul_mem_dev u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .a_valid_i(a_valid), .a_ready_o(a_ready),
    .a_opcode_i(a_opcode), .a_size_i(a_size), .a_source_i(a_source),
    .a_address_i(a_address), .a_mask_i(a_mask), .a_data_i(a_data),
    .d_valid_o(d_valid), .d_ready_i(d_ready), .d_opcode_o(d_opcode),
    .d_size_o(d_size), .d_source_o(d_source), .d_data_o(d_data), .d_error_o(d_error)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // one request with d_ready high; response sampled at the following negedge
  task automatic req(input logic [2:0] op, input logic [1:0] sz, input logic [7:0] src,
                     input logic [31:0] addr, input logic [3:0] msk, input logic [31:0] dat);
    @(negedge clk);
    a_valid = 1; a_opcode = op; a_size = sz; a_source = src;
    a_address = addr; a_mask = msk; a_data = dat; d_ready = 1;
    @(negedge clk);
    a_valid = 0;
  endtask

  function automatic logic [31:0] pat(int i);
    return 32'h9E37_79B9 * (i + 3) ^ {4{8'(i)}};
  endfunction

  function automatic logic [31:0] merge(logic [31:0] old, logic [31:0] nw, logic [3:0] m);
    logic [31:0] r = old;
    for (int k = 0; k < 4; k++) if (m[k]) r[8*k +: 8] = nw[8*k +: 8];
    return r;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 d_valid in reset", {31'd0, d_valid}, 0);
    chk("R1 a_ready in reset", {31'd0, a_ready}, 1);
    rst_ni = 1;
    for (int i = 0; i < DEPTH; i++) begin
      req(3'd4, 2'd2, 8'(i), 32'(i * 4), 4'hF, 0);
      chk("R1 word zero after reset", d_data, 0);
      model[i] = 0;
    end
    // full-word fill and readback
    for (int i = 0; i < DEPTH; i++) begin
      req(3'd0, 2'd2, 8'(i + 16), 32'(i * 4), 4'hF, pat(i));
      chk("R4 full write opcode", {29'd0, d_opcode}, 0);
      chk("R5 source echo write", {24'd0, d_source}, 32'(i + 16));
      model[i] = pat(i);
    end
    for (int i = 0; i < DEPTH; i++) begin
      req(3'd4, 2'd2, 8'(200 - i), 32'(i * 4) | 32'(i % 4), 4'(1 << (i % 4)), 0);
      chk("R2 get opcode", {29'd0, d_opcode}, 1);
      chk("R2 get data whole word", d_data, model[i]);
      chk("R2 get no error", {31'd0, d_error}, 0);
      chk("R5 source echo get", {24'd0, d_source}, 32'(200 - i));
    end
    // every mask value as a partial write to word 5
    for (int m = 0; m < 16; m++) begin
      logic [31:0] nw = 32'hC0DE_0000 + 32'(m * 32'h0101_0101);
      req(3'd1, 2'd2, 8'(m), 32'd20, 4'(m), nw);
      chk("R3 partial opcode", {29'd0, d_opcode}, 0);
      chk("R3 partial d_data zero", d_data, 0);
      model[5] = merge(model[5], nw, 4'(m));
      req(3'd4, 2'd2, 8'd1, 32'd20, 4'hF, 0);
      chk("R3 lanes after partial write", d_data, model[5]);
    end
    // gapped mask 1001 on word 9
    req(3'd1, 2'd1, 8'd7, 32'd36, 4'b1001, 32'hAABB_CCDD);
    model[9] = merge(model[9], 32'hAABB_CCDD, 4'b1001);
    req(3'd4, 2'd2, 8'd7, 32'd36, 4'hF, 0);
    chk("R3 gapped mask 1001", d_data, model[9]);
    // size echo
    for (int s = 0; s < 3; s++) begin
      req(3'd4, 2'(s), 8'd9, 32'd8, 4'b0001, 0);
      chk("R5 size echo get", {30'd0, d_size}, 32'(s));
      req(3'd1, 2'(s), 8'd9, 32'd8, 4'b0000, 0);
      chk("R5 size echo write", {30'd0, d_size}, 32'(s));
    end
    // out of range
    req(3'd0, 2'd2, 8'd3, 32'(DEPTH * 4), 4'hF, 32'hDEAD_BEEF);
    chk("R8 oob write error", {31'd0, d_error}, 1);
    chk("R8 oob write opcode", {29'd0, d_opcode}, 0);
    req(3'd4, 2'd2, 8'd3, 32'(DEPTH * 4 + 12), 4'hF, 0);
    chk("R8 oob get error", {31'd0, d_error}, 1);
    chk("R8 oob get opcode", {29'd0, d_opcode}, 1);
    chk("R8 oob get data", d_data, 0);
    req(3'd4, 2'd2, 8'd3, 32'd0, 4'hF, 0);
    chk("R8 aliased word unchanged", d_data, model[0]);
    // unserved opcode
    req(3'd2, 2'd2, 8'd4, 32'd12, 4'hF, 32'h1234_5678);
    chk("R9 bad opcode error", {31'd0, d_error}, 1);
    chk("R9 bad opcode ack", {29'd0, d_opcode}, 0);
    req(3'd4, 2'd2, 8'd4, 32'd12, 4'hF, 0);
    chk("R9 no write on bad opcode", d_data, model[3]);
    // back-pressure
    @(negedge clk);
    a_valid = 1; a_opcode = 3'd4; a_size = 2; a_source = 8'h55;
    a_address = 32'd28; a_mask = 4'hF; d_ready = 0;
    @(negedge clk);
    chk("R6 valid after accept", {31'd0, d_valid}, 1);
    chk("R7 a_ready low stalled", {31'd0, a_ready}, 0);
    a_opcode = 3'd0; a_address = 32'd28; a_data = 32'hFFFF_0000; a_source = 8'h66;
    repeat (3) @(negedge clk);
    chk("R6 held valid", {31'd0, d_valid}, 1);
    chk("R6 held data", d_data, model[7]);
    chk("R6 held source", {24'd0, d_source}, 32'h55);
    a_valid = 0; d_ready = 1;
    @(negedge clk);
    chk("R6 valid drops after ready", {31'd0, d_valid}, 0);
    req(3'd4, 2'd2, 8'd1, 32'd28, 4'hF, 0);
    chk("R7 stalled write ignored", d_data, model[7]);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog act=%0d exp=0", 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule